// File: doc/BRIEF.md
# Sequenced Indirect Register Port

This block puts a whole bank of peripheral registers behind two byte locations on a host bus. One location is a small pointer holding the low address bits of a register in the bank. The other location is a data window: a host read or write there is passed straight through to the register the pointer names. After each such transfer the pointer moves on by itself. It does not count up by one. It steps to the next entry of a fixed, sparse list of register addresses, so the gaps in the bank are skipped.

This lets a DMA engine reload every register of the bank by writing a block of bytes to a single fixed address. With the default list, an 18-byte burst that starts with the pointer at 0x02 touches every register exactly once. The pointer ends up back at 0x02, ready for the next burst. The block also produces the DMA request for the peripheral. It passes the peripheral's own request through, registered, only while the DMA engine has the data window selected as its destination.

Top module: `iap_port`

## Requirements
- R1: While `rst_n` is low and right after it rises, the pointer reads back as 0x02, which is the lowest address in the list, and `dma_req` is 0.
- R2: A read at bus location 0 (`bus_addr`=0) returns the pointer in bits 4:0 of `bus_rdata`, with bits 7:5 always zero. The bank is not strobed by this read.
- R3: A write at bus location 0 loads `bus_wdata[4:0]` into the pointer and drops bits 7:5. Neither a write nor a read of the pointer location moves the pointer on its own.
- R4: A write at bus location 1 raises `bank_wr` in the same cycle. In that cycle `bank_addr` equals the pointer and `bank_wdata` equals `bus_wdata`.
- R5: A read at bus location 1 raises `bank_rd` and returns `bank_rdata` on `bus_rdata` in the same cycle, with `bank_addr` equal to the pointer.
- R6: In the cycle after a data-window transfer, the pointer holds the next entry of the list 0x02, 0x03, 0x08 to 0x0F, 0x18 to 0x1F.
- R7: A data-window transfer at address 0x1F sets the pointer back to 0x02.
- R8: If the pointer holds an address that is not in the list, the next transfer uses that address. The pointer then moves to the smallest list entry above it, or to 0x02 if no entry is above it.
- R9: `dma_req` equals `periph_req AND dma_dst_sel` as sampled at the previous clock edge.
- R10: In a cycle with no bus strobe, neither `bank_wr` nor `bank_rd` is raised and the pointer keeps its value.
- R11: Starting from pointer 0x02, 18 back-to-back data-window transfers visit every list entry once, in ascending order, and leave the pointer at 0x02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 1 | Bus location: 0 selects the pointer, 1 selects the data window |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| bank_addr | output | 5 | Register address presented to the bank (the pointer) |
| bank_wr | output | 1 | Bank write strobe |
| bank_rd | output | 1 | Bank read strobe |
| bank_wdata | output | 8 | Bank write data |
| bank_rdata | input | 8 | Bank read data for `bank_addr` |
| periph_req | input | 1 | Transfer request from the peripheral |
| dma_dst_sel | input | 1 | DMA destination is the data window |
| dma_req | output | 1 | Registered DMA request |

## Verification
The hardest cases to reach are the pointer values that are not in the list and the step from the last entry back to the first. A DMA-style burst that starts at 0x02 never reaches either one. The stimulus therefore first loads the pointer directly with addresses inside the gaps (0x05, 0x10, 0x00) and with 0x1F. It then makes one data-window transfer and reads the pointer back through location 0 to see where it landed. A separate full 18-transfer write burst, followed by an 18-transfer read burst, confirms that the whole sequence visits each entry and closes on itself.

// File: rtl/iap_pkg.sv
// Package: shared types for the sequenced indirect register port.
// Assumes a two-location host map: pointer at 0, data window at 1.
package iap_pkg;

    // Host bus location decoded from the single address bit.
    typedef enum logic {
        LOC_PTR  = 1'b0,
        LOC_DATA = 1'b1
    } loc_e;

    // Kind of host transfer seen in the current cycle.
    typedef enum logic [1:0] {
        XFER_NONE    = 2'd0,
        XFER_PTR_WR  = 2'd1,
        XFER_DATA_WR = 2'd2,
        XFER_DATA_RD = 2'd3
    } xfer_e;

endpackage

// File: rtl/iap_ptr_reg.sv
// Module: pointer register with sequenced advance.
// Holds the bank address. A direct load takes priority over an advance.
// An advance moves to the smallest member of SEQ_MASK above the current
// value, or wraps to the smallest member. The reset value is that smallest member.
// Assumes SEQ_MASK has at least one bit set.
module iap_ptr_reg #(
    parameter int unsigned PTR_W = 5,
    parameter int unsigned DEPTH = 1 << PTR_W,
    parameter logic [DEPTH-1:0] SEQ_MASK = 32'hFF00_FF0C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             advance,
    output logic [PTR_W-1:0] ptr_q
);

    // Lowest member of the sequence mask.
    function automatic logic [PTR_W-1:0] first_member(input logic [DEPTH-1:0] m);
        logic [PTR_W-1:0] r;
        r = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (m[i]) r = PTR_W'(i);
        end
        return r;
    endfunction

    localparam logic [PTR_W-1:0] PTR_RST = first_member(SEQ_MASK);

    // Next member strictly above cur, else wrap to the first member.
    function automatic logic [PTR_W-1:0] next_member(input logic [PTR_W-1:0] cur);
        logic [PTR_W-1:0] r;
        logic found;
        r = '0;
        found = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (SEQ_MASK[i] && (i > int'(cur))) begin
                r = PTR_W'(i);
                found = 1'b1;
            end
        end
        return found ? r : PTR_RST;
    endfunction

    logic [PTR_W-1:0] ptr_d;

    // Select the next pointer value from load, advance or hold.
    always_comb begin
        if (load)         ptr_d = load_val;
        else if (advance) ptr_d = next_member(ptr_q);
        else              ptr_d = ptr_q;
    end

    // Pointer state with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= PTR_RST;
        else        ptr_q <= ptr_d;
    end

endmodule

// File: rtl/iap_bus_decode.sv
// Module: host bus decode and read mux.
// Classifies each cycle's strobe as a pointer write, a data-window write or
// a data-window read, drives the bank strobes, and selects the read data.
// Assumes single-cycle strobes. A write wins if both strobes are high.
module iap_bus_decode
    import iap_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PTR_W  = 5
) (
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [PTR_W-1:0]  ptr_q,
    input  logic [DATA_W-1:0] bank_rdata,
    output logic              ptr_load,
    output logic              ptr_advance,
    output logic              bank_wr,
    output logic              bank_rd,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int unsigned PAD_W = DATA_W - PTR_W;

    xfer_e xfer;
    loc_e  loc;

    assign loc = loc_e'(bus_addr);

    // Classify the current host transfer.
    always_comb begin
        if (bus_wr)                        xfer = (loc == LOC_PTR) ? XFER_PTR_WR : XFER_DATA_WR;
        else if (bus_rd && loc == LOC_DATA) xfer = XFER_DATA_RD;
        else                               xfer = XFER_NONE;
    end

    // Turn the transfer kind into pointer and bank controls.
    always_comb begin
        ptr_load    = (xfer == XFER_PTR_WR);
        bank_wr     = (xfer == XFER_DATA_WR);
        bank_rd     = (xfer == XFER_DATA_RD);
        ptr_advance = bank_wr || bank_rd;
    end

    // Read mux: zero-extended pointer or bank data.
    always_comb begin
        if (loc == LOC_PTR) bus_rdata = {{PAD_W{1'b0}}, ptr_q};
        else                bus_rdata = bank_rdata;
    end

endmodule

// File: rtl/iap_dma_req.sv
// Module: registered DMA request gate.
// Passes the peripheral request to the DMA engine only while the engine's
// destination is the data window. Adds one register stage.
module iap_dma_req (
    input  logic clk,
    input  logic rst_n,
    input  logic periph_req,
    input  logic dma_dst_sel,
    output logic dma_req
);

    // Gate and register the request.
    always_ff @(posedge clk) begin
        if (!rst_n) dma_req <= 1'b0;
        else        dma_req <= periph_req && dma_dst_sel;
    end

endmodule

// File: rtl/iap_port.sv
// Module: sequenced indirect register port (top).
// Exposes a pointer and a data window on a byte bus. Data-window transfers
// go to the bank register the pointer names, and the pointer then steps through
// the sparse list given by SEQ_MASK. Also gates the DMA request.
// Assumes the bank returns bank_rdata combinationally for bank_addr.
module iap_port #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PTR_W  = 5,
    parameter logic [(1 << PTR_W)-1:0] SEQ_MASK = 32'hFF00_FF0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [PTR_W-1:0]  bank_addr,
    output logic              bank_wr,
    output logic              bank_rd,
    output logic [DATA_W-1:0] bank_wdata,
    input  logic [DATA_W-1:0] bank_rdata,
    input  logic              periph_req,
    input  logic              dma_dst_sel,
    output logic              dma_req
);

    localparam int unsigned DEPTH = 1 << PTR_W;

    logic             ptr_load;
    logic             ptr_advance;
    logic [PTR_W-1:0] ptr_q;

    iap_bus_decode #(
        .DATA_W (DATA_W),
        .PTR_W  (PTR_W)
    ) u_dec (
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .ptr_q       (ptr_q),
        .bank_rdata  (bank_rdata),
        .ptr_load    (ptr_load),
        .ptr_advance (ptr_advance),
        .bank_wr     (bank_wr),
        .bank_rd     (bank_rd),
        .bus_rdata   (bus_rdata)
    );

    iap_ptr_reg #(
        .PTR_W    (PTR_W),
        .DEPTH    (DEPTH),
        .SEQ_MASK (SEQ_MASK)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (bus_wdata[PTR_W-1:0]),
        .advance  (ptr_advance),
        .ptr_q    (ptr_q)
    );

    iap_dma_req u_dma (
        .clk         (clk),
        .rst_n       (rst_n),
        .periph_req  (periph_req),
        .dma_dst_sel (dma_dst_sel),
        .dma_req     (dma_req)
    );

    assign bank_addr  = ptr_q;
    assign bank_wdata = bus_wdata;

endmodule

// File: rtl/iap_port_chk.sv
// Module: assertion checker for iap_port, attached by bind.
// Observes only top-level ports and checks pointer sequencing,
// pointer loads, idle hold and the DMA request timing.
module iap_port_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PTR_W  = 5,
    parameter logic [(1 << PTR_W)-1:0] SEQ_MASK = 32'hFF00_FF0C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [PTR_W-1:0]  bank_addr,
    input logic              bank_wr,
    input logic              bank_rd,
    input logic              periph_req,
    input logic              dma_dst_sel,
    input logic              dma_req
);

    localparam int unsigned DEPTH = 1 << PTR_W;

    // Highest and lowest members of the list.
    function automatic logic [PTR_W-1:0] top_member(input logic [DEPTH-1:0] m);
        logic [PTR_W-1:0] r;
        r = '0;
        for (int i = 0; i < DEPTH; i++) if (m[i]) r = PTR_W'(i);
        return r;
    endfunction

    function automatic logic [PTR_W-1:0] low_member(input logic [DEPTH-1:0] m);
        logic [PTR_W-1:0] r;
        r = '0;
        for (int i = DEPTH - 1; i >= 0; i--) if (m[i]) r = PTR_W'(i);
        return r;
    endfunction

    localparam logic [PTR_W-1:0] LAST  = top_member(SEQ_MASK);
    localparam logic [PTR_W-1:0] FIRST = low_member(SEQ_MASK);

    logic xfer;
    assign xfer = bank_wr || bank_rd;

    // R3: a pointer write lands the low data bits in the pointer.
    assert_ptr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr) |=> bank_addr == $past(bus_wdata[PTR_W-1:0]));

    // R6: after a transfer the pointer sits on a list member.
    assert_step_member_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> SEQ_MASK[bank_addr]);

    // R8: below the last member, a transfer moves the pointer strictly upward.
    assert_step_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && bank_addr < LAST) |=> bank_addr > $past(bank_addr));

    // R7: at or beyond the last member, a transfer wraps to the first.
    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && bank_addr >= LAST) |=> bank_addr == FIRST);

    // R10: with no strobe, the bank is left alone and the pointer holds.
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !bus_rd) |=> $stable(bank_addr));

    // R4: a bank write and a bank read never happen together.
    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bank_wr, bank_rd}));

    // R9: the DMA request follows the gated inputs one edge later.
    assert_dma_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> dma_req == $past(periph_req && dma_dst_sel));

endmodule

bind iap_port iap_port_chk #(
    .DATA_W   (DATA_W),
    .PTR_W    (PTR_W),
    .SEQ_MASK (SEQ_MASK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_wdata   (bus_wdata),
    .bank_addr   (bank_addr),
    .bank_wr     (bank_wr),
    .bank_rd     (bank_rd),
    .periph_req  (periph_req),
    .dma_dst_sel (dma_dst_sel),
    .dma_req     (dma_req)
);

// File: tb/iap_port_tb.sv
// Bench for iap_port: a vector table walked by one loop, then directed tests.
module iap_port_tb;

    localparam int CLK_HALF = 4;   // 125 MHz

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [4:0] bank_addr;
    logic       bank_wr;
    logic       bank_rd;
    logic [7:0] bank_wdata;
    logic [7:0] bank_rdata;
    logic       periph_req = 1'b0;
    logic       dma_dst_sel = 1'b0;
    logic       dma_req;

    int checks = 0;
    int failures = 0;

    always #(CLK_HALF) clk = ~clk;

    iap_port u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .bank_addr   (bank_addr),
        .bank_wr     (bank_wr),
        .bank_rd     (bank_rd),
        .bank_wdata  (bank_wdata),
        .bank_rdata  (bank_rdata),
        .periph_req  (periph_req),
        .dma_dst_sel (dma_dst_sel),
        .dma_req     (dma_req)
    );

    // Bank model: 32 bytes, preset to addr ^ 0x5A during reset.
    logic [7:0] mem [32];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) mem[i] <= 8'(i) ^ 8'h5A;
        end else if (bank_wr) begin
            mem[bank_addr] <= bank_wdata;
        end
    end
    assign bank_rdata = mem[bank_addr];

    // Expected register list, in visiting order.
    localparam logic [4:0] SEQ [18] = '{5'h02, 5'h03, 5'h08, 5'h09, 5'h0A, 5'h0B,
        5'h0C, 5'h0D, 5'h0E, 5'h0F, 5'h18, 5'h19, 5'h1A, 5'h1B, 5'h1C, 5'h1D, 5'h1E, 5'h1F};

    // Vector: op 0=pointer write, 1=window write (exp=bank_addr),
    // 2=window read (exp=data), 3=pointer read (exp=pointer).
    typedef struct packed {
        logic [1:0] op;
        logic [7:0] data;
        logic [7:0] exp;
    } vec_t;

    localparam int NVEC = 22;
    localparam vec_t VECS [NVEC] = '{
        '{2'd3, 8'h00, 8'h02},  // R1 reset pointer
        '{2'd0, 8'hE9, 8'h00},  // R3 upper bits dropped
        '{2'd3, 8'h00, 8'h09},  // R2 R3 readback
        '{2'd1, 8'h55, 8'h09},  // R4 write at pointer
        '{2'd3, 8'h00, 8'h0A},  // R6 step
        '{2'd1, 8'h56, 8'h0A},  // R4
        '{2'd3, 8'h00, 8'h0B},  // R6
        '{2'd0, 8'h1F, 8'h00},
        '{2'd1, 8'h66, 8'h1F},  // R4 last member
        '{2'd3, 8'h00, 8'h02},  // R7 wrap
        '{2'd0, 8'h05, 8'h00},
        '{2'd1, 8'h77, 8'h05},  // R8 gap address used
        '{2'd3, 8'h00, 8'h08},  // R8 next higher
        '{2'd0, 8'h10, 8'h00},
        '{2'd2, 8'h00, 8'h4A},  // R5 read at gap 0x10
        '{2'd3, 8'h00, 8'h18},  // R8
        '{2'd0, 8'h00, 8'h00},
        '{2'd2, 8'h00, 8'h5A},  // R5 read at 0x00
        '{2'd3, 8'h00, 8'h02},  // R8 below first member
        '{2'd2, 8'h00, 8'h58},  // R5 read at 0x02
        '{2'd0, 8'h09, 8'h00},
        '{2'd2, 8'h00, 8'h55}   // R5 data written earlier
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, sample 1 ns later (before posedge).
    task automatic bus_op(input logic [1:0] op, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = (op != 2'd0 && op != 2'd3);
        bus_wr    = (op == 2'd0 || op == 2'd1);
        bus_rd    = (op == 2'd2 || op == 2'd3);
        bus_wdata = d;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
        #1;
    endtask

    task automatic ptr_expect(input logic [4:0] e, input string req);
        bus_op(2'd3, 8'h00);
        check(bus_rdata == {3'b000, e} && !bank_rd, req, bus_rdata, e);
    endtask

    bit done = 1'b0;

    initial begin
        #(2 * CLK_HALF * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(dma_req == 1'b0, "R1", dma_req, 0);
        rst_n = 1'b1;

        // Table walk.
        for (int v = 0; v < NVEC; v++) begin
            bus_op(VECS[v].op, VECS[v].data);
            case (VECS[v].op)
                2'd1: check(bank_wr && bank_addr == VECS[v].exp[4:0] && bank_wdata == VECS[v].data,
                            "R4", bank_addr, VECS[v].exp);
                2'd2: check(bank_rd && bus_rdata == VECS[v].exp, "R5", bus_rdata, VECS[v].exp);
                2'd3: check(bus_rdata == VECS[v].exp && !bank_rd, "R2", bus_rdata, VECS[v].exp);
                default: ;
            endcase
        end

        // R10: idle cycles leave the bank alone and the pointer in place (0x0A).
        for (int i = 0; i < 5; i++) begin
            idle();
            check(!bank_wr && !bank_rd, "R10", {bank_wr, bank_rd}, 0);
        end
        ptr_expect(5'h0A, "R10");
        ptr_expect(5'h0A, "R3");   // pointer read does not move it

        // R11: full write burst, then full read burst.
        bus_op(2'd0, 8'h02);
        for (int i = 0; i < 18; i++) begin
            bus_op(2'd1, 8'hC0 + 8'(i));
            check(bank_wr && bank_addr == SEQ[i], "R11", bank_addr, SEQ[i]);
        end
        ptr_expect(5'h02, "R11");
        for (int i = 0; i < 18; i++) begin
            bus_op(2'd2, 8'h00);
            check(bank_addr == SEQ[i] && bus_rdata == 8'hC0 + 8'(i), "R11", bus_rdata, 8'hC0 + 8'(i));
        end
        ptr_expect(5'h02, "R11");
        idle();

        // R9: request gating and one-cycle lag.
        periph_req = 1'b1;
        dma_dst_sel = 1'b0;
        @(negedge clk); #1;
        check(dma_req == 1'b0, "R9", dma_req, 0);
        dma_dst_sel = 1'b1;
        #1;
        check(dma_req == 1'b0, "R9", dma_req, 0);
        @(negedge clk); #1;
        check(dma_req == 1'b1, "R9", dma_req, 1);
        periph_req = 1'b0;
        @(negedge clk); #1;
        check(dma_req == 1'b0, "R9", dma_req, 0);

        // R1: reset in mid-run returns the pointer to 0x02 and clears dma_req.
        periph_req = 1'b1;
        bus_op(2'd0, 8'h1C);
        idle();
        rst_n = 1'b0;
        @(negedge clk); #1;
        check(dma_req == 1'b0, "R1", dma_req, 0);
        ptr_expect(5'h02, "R1");
        idle();
        rst_n = 1'b1;
        periph_req = 1'b0;
        dma_dst_sel = 1'b0;
        ptr_expect(5'h02, "R1");
        idle();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule